// File: doc/BRIEF.md
# SPI Port with Master/Slave Roles and Multi-Master Fault Detection

This block is one serial peripheral interface port that works either as the bus master or as a slave. A master-select bit in the control register picks the role. A host reaches the port through a small register interface that has three registers: control, status and data. The port has an interrupt request line. It drives the SCK, MOSI, MISO and slave-select pads, and each pad has its own output enable. Clock polarity and clock phase choose one of the four usual transfer formats. Bytes go out most significant bit first.

As a slave, the port only works while its slave-select input is low. When slave-select is released, the shift logic returns to its start state and any part of a byte that was shifted in is discarded. As a master, the slave-select pad can be a plain output, or it can be an input that watches for another master. If that input is pulled low, the port stops driving the bus, falls back to slave operation and sets its completion flag. It stays a slave until software sets the master bit again. In slave operation, SCK, MOSI and slave-select pass through a two-stage synchronizer, so the system clock must run at least four times faster than SCK.

Host register map (`host_addr`):
- Address 0 is control: bit 0 master, bit 1 clock polarity, bit 2 clock phase, bit 3 interrupt enable, bit 4 slave MISO drive enable, bit 5 slave-select pad is an output in master mode, bit 6 level driven on that pad.
- Address 1 is status: bit 7 is the completion flag.
- Address 2 is data: a write sends a byte, a read returns the last byte received.

Read data is registered. It is valid the cycle after `host_rd` is asserted.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset, the control register reads 0 (slave role), the status flag is 0, `irq` is 0, and all four output enables are 0.
- R2: In master mode, a write to the data register runs 8 SCK cycles. SCK idles at the level of control bit 1. The written byte is sent MSB first on MOSI. The byte sampled from MISO is readable at address 2, and status bit 7 is set at the end.
- R3: With phase 0, a bit is valid before the first SCK edge of its cycle, is sampled on the leading edge and changes on the trailing edge. With phase 1, it changes on the leading edge and is sampled on the trailing edge.
- R4: In slave mode with slave-select low, the port exchanges a byte with an external master in all four formats. It sends the byte last written to address 2 on MISO and stores the byte taken from MOSI.
- R5: In slave mode with slave-select high, SCK and MOSI activity receives nothing: the flag stays 0 and address 2 keeps its value.
- R6: A rising slave-select in slave mode discards a partly shifted byte. The next selection starts again from the first bit of the transmit byte.
- R7: In slave mode, `miso_oe` is 1 only while slave-select is low and control bit 4 is 1. `sck_oe`, `mosi_oe` and `ss_oe` stay 0.
- R8: In master mode with control bit 5 set, `ss_oe` is 1, `ss_o` follows control bit 6, and a low `ss_i` has no effect on the role.
- R9: In master mode with control bit 5 clear, a low `ss_i` clears control bit 0, drops `sck_oe` and `mosi_oe`, and sets status bit 7.
- R10: After such a fault, the port stays in the slave role until the host writes 1 to control bit 0. That write restores the master pad drivers.
- R11: `irq` is 1 exactly when status bit 7 and control bit 3 are both 1 and `global_ie` is 1.
- R12: Status bit 7 clears only when the status register is read while the bit is set and the data register is accessed afterwards. A data access on its own leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| global_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK pad output |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO pad output |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Slave-select pad input |
| ss_o | output | 1 | Slave-select pad output |
| ss_oe | output | 1 | Slave-select output enable |

## Verification
A wrong bit count or a stale shift register shows up within one byte: the data register and the byte seen by the bench partner both come out rotated or mixed. Missed clearing on deselect only shows on the transfer after a partial one. A lost fault demotion shows within a few cycles as `sck_oe` still high and the master bit still set after `ss_i` falls. A wrong flag state shows at once on `irq` and on the status read.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef struct packed {
    logic ss_lvl;   // bit 6
    logic ss_out;   // bit 5
    logic miso_en;  // bit 4
    logic irq_en;   // bit 3
    logic cpha;     // bit 2
    logic cpol;     // bit 1
    logic master;   // bit 0
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int HALF_DIV = 4,
  parameter int EDGES    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic cpol,
  output logic sck_o,
  output logic busy_o,
  output logic lead_p,
  output logic trail_p
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EW = $clog2(EDGES);

  logic [DW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic          busy_q, phase_q, lead_q, trail_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      div_q   <= '0;
      edge_q  <= '0;
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        div_q   <= '0;
        edge_q  <= '0;
        phase_q <= 1'b0;
      end else if (busy_q) begin
        if (div_q == DW'(HALF_DIV - 1)) begin
          div_q   <= '0;
          phase_q <= ~phase_q;
          lead_q  <= ~edge_q[0];
          trail_q <= edge_q[0];
          edge_q  <= edge_q + 1'b1;
          if (edge_q == EW'(EDGES - 1)) busy_q <= 1'b0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sck_o   = cpol ^ phase_q;
  assign busy_o  = busy_q;
  assign lead_p  = lead_q;
  assign trail_p = trail_q;

  AST_IDLE_AT_REST: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(busy_q) && !$past(start)) |-> !phase_q); // R2
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         clear,
  input  logic         drive_p,
  input  logic         samp_p,
  input  logic         sin,
  output logic         sout,
  output logic         done_p,
  output logic [W-1:0] rx_data
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          out_q, done_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (load) begin
      sr_q   <= ld_data;
      out_q  <= ld_data[W-1];
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (drive_p) out_q <= sr_q[W-1];
      if (samp_p) begin
        sr_q <= {sr_q[W-2:0], sin};
        if (cnt_q == CW'(W - 1)) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sout    = out_q;
  assign done_p  = done_q;
  assign rx_data = sr_q;

  AST_DONE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R2
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              global_ie,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] tx_buf_q, rx_buf_q;
  logic              flag_q, armed_q;
  logic              sck_prev_q, ss_prev_q;

  // synchronized slave-side inputs: {ss, sck, mosi}
  logic [2:0] sync_out;
  logic       ss_s, sck_s, mosi_s;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst (rst),
    .d_i ({ss_i, sck_i, mosi_i}),
    .q_o (sync_out)
  );
  assign {ss_s, sck_s, mosi_s} = sync_out;

  logic master_q, fault, sel, ss_fall, ss_rise;
  logic s_lead, s_trail;
  assign master_q = ctrl_q.master;
  assign fault    = master_q && !ctrl_q.ss_out && !ss_s;
  assign sel      = !master_q && !ss_s;
  assign ss_fall  = ss_prev_q && !ss_s;
  assign ss_rise  = !ss_prev_q && ss_s;
  assign s_lead   = sel && (ctrl_q.cpol ? (sck_prev_q && !sck_s) : (!sck_prev_q && sck_s));
  assign s_trail  = sel && (ctrl_q.cpol ? (!sck_prev_q && sck_s) : (sck_prev_q && !sck_s));

  logic data_wr, data_rd, stat_rd, m_start;
  assign data_wr = host_wr && (host_addr == ADDR_DATA);
  assign data_rd = host_rd && (host_addr == ADDR_DATA);
  assign stat_rd = host_rd && (host_addr == ADDR_STAT);

  logic m_sck, m_busy, m_lead, m_trail;
  assign m_start = master_q && data_wr && !m_busy && !fault;

  spi_sclk_gen #(.HALF_DIV(HALF_DIV), .EDGES(EDGES)) u_clkgen (
    .clk (clk), .rst (rst), .start (m_start), .abort (fault),
    .cpol (ctrl_q.cpol), .sck_o (m_sck), .busy_o (m_busy),
    .lead_p (m_lead), .trail_p (m_trail)
  );

  logic lead_ev, trail_ev, core_load, core_clear, core_sin, core_out, core_done;
  logic [DATA_W-1:0] core_rx, core_ld;
  assign lead_ev    = master_q ? m_lead  : s_lead;
  assign trail_ev   = master_q ? m_trail : s_trail;
  assign core_load  = m_start || (!master_q && ss_fall);
  assign core_ld    = master_q ? host_wdata : tx_buf_q;
  assign core_clear = fault || (!master_q && ss_rise);
  assign core_sin   = master_q ? miso_i : mosi_s;

  spi_shift_core #(.W(DATA_W)) u_core (
    .clk (clk), .rst (rst),
    .load (core_load), .ld_data (core_ld), .clear (core_clear),
    .drive_p (ctrl_q.cpha ? lead_ev : trail_ev),
    .samp_p  (ctrl_q.cpha ? trail_ev : lead_ev),
    .sin (core_sin), .sout (core_out),
    .done_p (core_done), .rx_data (core_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      tx_buf_q   <= '0;
      rx_buf_q   <= '0;
      flag_q     <= 1'b0;
      armed_q    <= 1'b0;
      sck_prev_q <= 1'b0;
      ss_prev_q  <= 1'b1;
      host_rdata <= '0;
    end else begin
      sck_prev_q <= sck_s;
      ss_prev_q  <= ss_s;
      if (host_wr && host_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(host_wdata[CTRL_W-1:0]);
      if (fault) ctrl_q.master <= 1'b0;
      if (data_wr && !master_q) tx_buf_q <= host_wdata;
      if (core_done) rx_buf_q <= core_rx;
      // completion flag: set wins over the read-status-then-data clear
      if (core_done || fault) begin
        flag_q <= 1'b1;
      end else if (armed_q && (data_rd || data_wr)) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end
      if (stat_rd && flag_q) armed_q <= 1'b1;
      else if (data_rd || data_wr) armed_q <= 1'b0;
      if (host_rd) begin
        case (host_addr)
          ADDR_CTRL: host_rdata <= DATA_W'(ctrl_q);
          ADDR_STAT: host_rdata <= {flag_q, {(DATA_W-1){1'b0}}};
          ADDR_DATA: host_rdata <= rx_buf_q;
          default:   host_rdata <= '0;
        endcase
      end
    end
  end

  assign irq     = flag_q && ctrl_q.irq_en && global_ie;
  assign sck_o   = m_sck;
  assign sck_oe  = master_q;
  assign mosi_o  = core_out;
  assign mosi_oe = master_q;
  assign miso_o  = core_out;
  assign miso_oe = sel && ctrl_q.miso_en;
  assign ss_o    = ctrl_q.ss_lvl;
  assign ss_oe   = master_q && ctrl_q.ss_out;

  AST_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (rst)
    (master_q && !ctrl_q.ss_out && !ss_s) |=> !master_q); // R9
  AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (master_q && !ctrl_q.ss_out && !ss_s) |=> flag_q); // R9
  AST_PASSIVE_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!master_q && ss_s && $past(ss_s) && !$past(master_q)) |-> !core_done); // R5
  AST_SS_OUT_KEEPS_ROLE: assert property (@(posedge clk) disable iff (rst)
    (master_q && ctrl_q.ss_out && !(host_wr && host_addr == ADDR_CTRL)) |=> master_q); // R8
endmodule

// File: tb/spi_duplex_port_tb.sv
module spi_duplex_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 8;  // bench-master SCK half period in clocks

  logic clk = 1'b0, rst = 1'b1;
  logic host_wr = 0, host_rd = 0, global_ie = 1;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_i = 1;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] rd, got, last_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_duplex_port dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .global_ie(global_ie), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  // {master, cpol, cpha, byte written to DUT, byte from bench partner}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 8'hA5, 8'h3C}, {1'b1, 1'b0, 1'b1, 8'h81, 8'h7E},
    {1'b1, 1'b1, 1'b0, 8'h5A, 8'hC3}, {1'b1, 1'b1, 1'b1, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 1'b0, 8'h96, 8'h69}, {1'b0, 1'b0, 1'b1, 8'h01, 8'h80},
    {1'b0, 1'b1, 1'b0, 8'hE7, 8'h18}, {1'b0, 1'b1, 1'b1, 8'h2D, 8'hD2}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  // bench acts as external master driving the DUT slave
  task automatic slave_xfer(input bit cp, input bit ph, input logic [7:0] b,
                            input int nbits, output logic [7:0] g);
    g = 0;
    @(negedge clk); sck_i = cp; ss_i = 0; if (!ph) mosi_i = b[7];
    repeat (SH) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck_i = ~cp;
      if (ph) mosi_i = b[7-i]; else g = {g[6:0], miso_o};
      repeat (SH) @(negedge clk);
      sck_i = cp;
      if (ph) g = {g[6:0], miso_o}; else if (i < 7) mosi_i = b[6-i];
      repeat (SH) @(negedge clk);
    end
    ss_i = 1;
    repeat (SH) @(negedge clk);
  endtask

  // bench acts as external slave next to the DUT master
  task automatic master_xfer(input bit cp, input bit ph, input logic [7:0] tx,
                             input logic [7:0] p, output logic [7:0] g);
    int edges = 0, dcnt = ph ? 0 : 1, guard = 0;
    logic prev;
    g = 0; miso_i = p[7]; prev = cp;
    wr(2'd2, tx);
    while (edges < 16 && guard < 2000) begin
      @(negedge clk); guard++;
      if (sck_o != prev) begin
        bit lead = (edges % 2 == 0);
        prev = sck_o; edges++;
        if (lead != ph) g = {g[6:0], mosi_o};
        else begin
          if (dcnt < 8) miso_i = p[7-dcnt];
          dcnt++;
        end
      end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!sck_oe && !mosi_oe && !miso_oe && !ss_oe, "R1 enables", {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
    check(!irq, "R1 irq", irq, 0);
    rdreg(2'd0, rd); check(rd == 8'h00, "R1 ctrl", rd, 8'h00);
    rdreg(2'd1, rd); check(rd == 8'h00, "R1 status", rd, 8'h00);

    // table walk: R2/R3 (master) and R4/R3 (slave)
    for (int i = 0; i < 8; i++) begin
      logic m, cp, ph;
      logic [7:0] tx, pb;
      {m, cp, ph, tx, pb} = VEC[i];
      if (m) begin
        wr(2'd0, {1'b1, 1'b1, 3'b000, ph, cp, 1'b1});
        @(negedge clk);
        check(sck_o == cp, "R2 sck idle level", sck_o, cp);
        master_xfer(cp, ph, tx, pb, got);
        check(got == tx, "R3 master MOSI byte", got, tx);
      end else begin
        wr(2'd0, {3'b001, 2'b00, ph, cp, 1'b0});
        wr(2'd2, tx);
        slave_xfer(cp, ph, pb, 8, got);
        check(got == tx, "R4 slave MISO byte", got, tx);
      end
      rdreg(2'd1, rd); check(rd[7], m ? "R2 flag" : "R4 flag", rd, 8'h80);
      rdreg(2'd2, rd); check(rd == pb, m ? "R2 rx data" : "R4 rx data", rd, pb);
      last_rx = pb;
    end

    // R5 passive slave
    wr(2'd0, 8'h10);
    ss_i = 1;
    for (int k = 0; k < 16; k++) begin
      sck_i = ~sck_i; mosi_i = k[1];
      repeat (SH) @(negedge clk);
      check(!miso_oe, "R5 miso not driven", miso_oe, 0);
    end
    rdreg(2'd1, rd); check(rd == 8'h00, "R5 flag stays clear", rd, 0);
    rdreg(2'd2, rd); check(rd == last_rx, "R5 rx unchanged", rd, last_rx);

    // R7 output enables in slave
    wr(2'd0, 8'h00);
    @(negedge clk); ss_i = 0; repeat (6) @(negedge clk);
    check(!miso_oe && !sck_oe && !mosi_oe && !ss_oe, "R7 drive bit off", miso_oe, 0);
    wr(2'd0, 8'h10); @(negedge clk);
    check(miso_oe, "R7 miso driven", miso_oe, 1);
    ss_i = 1; repeat (6) @(negedge clk);
    check(!miso_oe, "R7 deselected", miso_oe, 0);

    // R6 partial byte dropped
    wr(2'd2, 8'h3C);
    slave_xfer(1'b0, 1'b0, 8'hFF, 3, got);
    slave_xfer(1'b0, 1'b0, 8'h5A, 8, got);
    check(got == 8'h3C, "R6 tx realigned", got, 8'h3C);
    rdreg(2'd1, rd);
    rdreg(2'd2, rd); check(rd == 8'h5A, "R6 rx realigned", rd, 8'h5A);

    // R8 slave-select as output
    wr(2'd0, 8'h61); @(negedge clk);
    check(ss_oe && ss_o, "R8 ss driven high", {ss_oe, ss_o}, 2'b11);
    wr(2'd0, 8'h21); @(negedge clk);
    check(ss_oe && !ss_o, "R8 ss driven low", {ss_oe, ss_o}, 2'b10);
    ss_i = 0; repeat (10) @(negedge clk);
    rdreg(2'd0, rd); check(rd == 8'h21, "R8 ss_i ignored", rd, 8'h21);
    check(sck_oe, "R8 sck still driven", sck_oe, 1);
    ss_i = 1; repeat (4) @(negedge clk);

    // R9 mode fault, R11 irq gating
    wr(2'd0, 8'h09); global_ie = 1;
    @(negedge clk); ss_i = 0; repeat (6) @(negedge clk);
    check(!sck_oe && !mosi_oe, "R9 drivers released", {sck_oe, mosi_oe}, 0);
    check(irq, "R9 flag via irq", irq, 1);
    global_ie = 0; @(negedge clk);
    check(!irq, "R11 global enable gates irq", irq, 0);
    global_ie = 1; @(negedge clk);
    check(irq, "R11 irq restored", irq, 1);
    rdreg(2'd0, rd); check(rd == 8'h08, "R9 master bit cleared", rd, 8'h08);

    // R10 stays slave until rewritten
    ss_i = 1; repeat (10) @(negedge clk);
    rdreg(2'd0, rd); check(rd[0] == 1'b0, "R10 remains slave", rd, 8'h08);
    check(!sck_oe, "R10 sck still released", sck_oe, 0);

    // R12 flag clear sequence
    rdreg(2'd2, rd); @(negedge clk);
    check(irq, "R12 data alone keeps flag", irq, 1);
    rdreg(2'd1, rd); check(rd[7], "R12 status shows flag", rd, 8'h80);
    rdreg(2'd2, rd); @(negedge clk);
    check(!irq, "R12 flag cleared", irq, 0);
    rdreg(2'd1, rd); check(rd == 8'h00, "R12 status clear", rd, 0);

    wr(2'd0, 8'h29); @(negedge clk);
    check(sck_oe && mosi_oe, "R10 master restored", {sck_oe, mosi_oe}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule